// File: doc/BRIEF.md
# Request-Acknowledge Random Generator Controller

This block is a register-mapped front end for a deterministic random generator. Software raises one of five request bits in a control register: instantiate, reseed, self-test, software DRNG or software TRNG. The block serves each newly raised request once, and when that operation ends it sets the matching bit in a state register. Software waits for that bit, clears it by writing back the value it read, reads any output words, and then drops the request.

The generator core is a 32-bit Galois LFSR. Instantiate loads a fixed seed and reseed mixes a constant into the current state. A software DRNG operation steps the core eight times and stores each new state as one output word. When several requests rise in the same cycle, they are served one after another in a fixed order. A DRNG request made before any instantiate first seeds the core on its own.

Top module: `reqack_drng`

## Requirements
- R1: After reset the control register, the state register and all eight output words read as zero.
- R2: The control register sits at byte offset 0x10 and holds request bits 0 instantiate, 1 reseed, 2 self-test, 3 software DRNG and 4 software TRNG. A write replaces all five bits. Bits 31..5 always read zero, so writing zero to the low half clears every request.
- R3: The state register sits at offset 0x14 and holds acknowledge bits at the same positions as the requests. A write clears each acknowledge bit where the written data has a one and leaves the others alone. Writing back the value just read clears every acknowledge bit that was set, and no write can set a bit.
- R4: A request starts one operation on its 0-to-1 transition only. Holding the bit high after its acknowledge has been cleared starts nothing further: the acknowledge stays 0 and the output words stay unchanged.
- R5: A software DRNG operation steps the LFSR eight times. Each step is next = (s >> 1) ^ (s[0] ? 32'h80200003 : 0). Output word k (k = 0..7) is the state after step k+1 and reads at offset 0x70 + 4*k. The core keeps the last state, and acknowledge bit 3 is set when the operation ends.
- R6: Instantiate loads the state with SEED_INIT (default 32'h6D2B79F5). Reseed replaces the state with state ^ RESEED_MIX (default 32'hC3A50F1E), or with SEED_INIT if that result is zero. Each sets its own acknowledge bit.
- R7: Requests pending together are served one at a time in the order instantiate, reseed, self-test, DRNG, TRNG. Their acknowledge bits rise in that order, each in a different cycle.
- R8: A DRNG request issued while the core has never been instantiated first loads SEED_INIT and then produces its eight words. Only acknowledge bit 3 is raised; the instantiate acknowledge stays 0.
- R9: The self-test and TRNG requests raise acknowledge bits 2 and 4 after a fixed latency. They leave the output words unchanged.
- R10: Offsets other than 0x10, 0x14 and the eight aligned word offsets read zero, and writes to them have no effect. The output words are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset for reads and writes |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |

## Verification
On every cycle the assertions check four things: acknowledge bits really clear under a one-write, at most one acknowledge rises per cycle, the seeded core never holds a zero state, and the output words change only on DRNG steps. They also check that the control readback never shows upper bits. Only the bench scenarios can show that the word values match the LFSR sequence from the right starting state. The same holds for the order in which acknowledges appear when all five requests rise together. Finally, the scenarios show that the implicit seeding happens and that a request held high does not repeat.

// File: rtl/reqack_drng_pkg.sv
package reqack_drng_pkg;

  // Request / acknowledge bit positions (software decodes these)
  localparam int REQ_N = 5;
  localparam int OP_W  = $clog2(REQ_N);
  localparam logic [OP_W-1:0] OP_INST   = 3'd0;
  localparam logic [OP_W-1:0] OP_RESEED = 3'd1;
  localparam logic [OP_W-1:0] OP_TEST   = 3'd2;
  localparam logic [OP_W-1:0] OP_DRNG   = 3'd3;
  localparam logic [OP_W-1:0] OP_TRNG   = 3'd4;

  // Register byte offsets
  localparam logic [7:0] OFS_CTRL      = 8'h10;
  localparam logic [7:0] OFS_STATE     = 8'h14;
  localparam logic [7:0] OFS_DATA_BASE = 8'h70;

  localparam int IDX_W = 4;   // word index field, supports up to 16 words

  typedef enum logic {
    FSM_IDLE = 1'b0,
    FSM_EXEC = 1'b1
  } fsmState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadSeed;
    logic             mixSeed;
    logic             stepWord;
    logic [IDX_W-1:0] wordIdx;
  } dpStrobe_t;

endpackage

// File: rtl/reqack_drng_ctrl.sv
module reqack_drng_ctrl
  import reqack_drng_pkg::*;
#(
  parameter int DATA_WORDS  = 8,
  parameter int TEST_CYCLES = 4,
  parameter int TRNG_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [REQ_N-1:0] ctrlWrData,
  input  logic [REQ_N-1:0] ackClr,
  input  logic             seeded,
  output dpStrobe_t        stb,
  output logic [REQ_N-1:0] ctrlReg,
  output logic [REQ_N-1:0] ackReg
);

  localparam int MAX_A   = (TEST_CYCLES > TRNG_CYCLES) ? TEST_CYCLES : TRNG_CYCLES;
  localparam int MAX_CNT = (MAX_A > DATA_WORDS) ? MAX_A : DATA_WORDS;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  logic [REQ_N-1:0] ctrlPrev;
  logic [REQ_N-1:0] pending;
  logic [REQ_N-1:0] takeMask;
  logic [REQ_N-1:0] ackSet;
  logic [OP_W-1:0]  pickIdx;
  logic [OP_W-1:0]  curOp;
  logic [CNT_W-1:0] cnt;
  logic             needSeed;
  logic             opDone;
  fsmState_t        fsmState;

  // Fixed priority: lowest bit index wins
  always_comb begin
    pickIdx = '0;
    for (int i = REQ_N - 1; i >= 0; i--) begin
      if (pending[i]) pickIdx = OP_W'(i);
    end
    takeMask = '0;
    if (fsmState == FSM_IDLE && |pending) takeMask[pickIdx] = 1'b1;
  end

  // Strobe generation for the running operation
  always_comb begin
    stb    = '0;
    ackSet = '0;
    opDone = 1'b0;
    if (fsmState == FSM_EXEC) begin
      case (curOp)
        OP_INST: begin
          stb.loadSeed = 1'b1;
          opDone       = 1'b1;
        end
        OP_RESEED: begin
          stb.mixSeed = 1'b1;
          opDone      = 1'b1;
        end
        OP_TEST:  opDone = (cnt == CNT_W'(TEST_CYCLES - 1));
        OP_TRNG:  opDone = (cnt == CNT_W'(TRNG_CYCLES - 1));
        OP_DRNG: begin
          if (needSeed) begin
            stb.loadSeed = 1'b1;
          end else begin
            stb.stepWord = 1'b1;
            stb.wordIdx  = IDX_W'(cnt);
            opDone       = (cnt == CNT_W'(DATA_WORDS - 1));
          end
        end
        default: opDone = 1'b1;
      endcase
      if (opDone) ackSet[curOp] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      ctrlPrev <= '0;
      pending  <= '0;
      ackReg   <= '0;
      fsmState <= FSM_IDLE;
      curOp    <= '0;
      cnt      <= '0;
      needSeed <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= ctrlWrData;
      ctrlPrev <= ctrlReg;
      pending  <= (pending & ~takeMask) | (ctrlReg & ~ctrlPrev);
      ackReg   <= (ackReg & ~ackClr) | ackSet;
      case (fsmState)
        FSM_IDLE: begin
          if (|pending) begin
            curOp    <= pickIdx;
            cnt      <= '0;
            needSeed <= (pickIdx == OP_DRNG) && !seeded;
            fsmState <= FSM_EXEC;
          end
        end
        FSM_EXEC: begin
          if (opDone) begin
            fsmState <= FSM_IDLE;
          end else if (curOp == OP_DRNG && needSeed) begin
            needSeed <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: fsmState <= FSM_IDLE;
      endcase
    end
  end

  AST_ACK_W1C: assert property (@(posedge clk) disable iff (!rstN)
    ((ackReg & ackClr & ~ackSet) != '0) |=> ((ackReg & $past(ackReg & ackClr & ~ackSet)) == '0)); // R3

  AST_ONE_ACK_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ackReg & ~$past(ackReg)) <= 1); // R7

  AST_WORD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepWord |-> (stb.wordIdx < IDX_W'(DATA_WORDS))); // R5

endmodule

// File: rtl/reqack_drng_datapath.sv
module reqack_drng_datapath
  import reqack_drng_pkg::*;
#(
  parameter int              DATA_WORDS = 8,
  parameter int              WORD_W     = 32,
  parameter logic [WORD_W-1:0] LFSR_TAPS  = 32'h80200003,
  parameter logic [WORD_W-1:0] SEED_INIT  = 32'h6D2B79F5,
  parameter logic [WORD_W-1:0] RESEED_MIX = 32'hC3A50F1E
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  output logic                         seeded,
  output logic [DATA_WORDS*WORD_W-1:0] dataFlat
);

  logic [WORD_W-1:0] genState;
  logic [WORD_W-1:0] nextStep;
  logic [WORD_W-1:0] mixed;

  function automatic logic [WORD_W-1:0] lfsrStep(input logic [WORD_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
  endfunction

  assign nextStep = lfsrStep(genState);
  assign mixed    = genState ^ RESEED_MIX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genState <= '0;
      seeded   <= 1'b0;
    end else if (stb.loadSeed) begin
      genState <= SEED_INIT;
      seeded   <= 1'b1;
    end else if (stb.mixSeed) begin
      genState <= (mixed == '0) ? SEED_INIT : mixed;
    end else if (stb.stepWord) begin
      genState <= nextStep;
    end
  end

  for (genvar k = 0; k < DATA_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] wordReg;
    always_ff @(posedge clk) begin
      if (!rstN) wordReg <= '0;
      else if (stb.stepWord && stb.wordIdx == IDX_W'(k)) wordReg <= nextStep;
    end
    assign dataFlat[k*WORD_W +: WORD_W] = wordReg;
  end

  AST_SEEDED_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    seeded |-> (genState != '0)); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stepWord |=> $stable(dataFlat)); // R9

endmodule

// File: rtl/reqack_drng.sv
module reqack_drng
  import reqack_drng_pkg::*;
#(
  parameter int                DATA_WORDS  = 8,
  parameter int                TEST_CYCLES = 4,
  parameter int                TRNG_CYCLES = 6,
  parameter logic [31:0]       LFSR_TAPS   = 32'h80200003,
  parameter logic [31:0]       SEED_INIT   = 32'h6D2B79F5,
  parameter logic [31:0]       RESEED_MIX  = 32'hC3A50F1E
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData
);

  localparam int WORD_W = 32;

  dpStrobe_t                    stb;
  logic                         seeded;
  logic [DATA_WORDS*WORD_W-1:0] dataFlat;
  logic [REQ_N-1:0]             ctrlReg;
  logic [REQ_N-1:0]             ackReg;
  logic                         ctrlWr;
  logic [REQ_N-1:0]             ackClr;
  logic                         unusedWrBits;

  assign ctrlWr       = busWrEn && (busAddr == OFS_CTRL);
  assign ackClr       = (busWrEn && busAddr == OFS_STATE) ? busWrData[REQ_N-1:0] : '0;
  assign unusedWrBits = ^busWrData[31:REQ_N];

  reqack_drng_ctrl #(
    .DATA_WORDS (DATA_WORDS),
    .TEST_CYCLES(TEST_CYCLES),
    .TRNG_CYCLES(TRNG_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWr    (ctrlWr),
    .ctrlWrData(busWrData[REQ_N-1:0]),
    .ackClr    (ackClr),
    .seeded    (seeded),
    .stb       (stb),
    .ctrlReg   (ctrlReg),
    .ackReg    (ackReg)
  );

  reqack_drng_datapath #(
    .DATA_WORDS(DATA_WORDS),
    .WORD_W    (WORD_W),
    .LFSR_TAPS (LFSR_TAPS),
    .SEED_INIT (SEED_INIT),
    .RESEED_MIX(RESEED_MIX)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .seeded  (seeded),
    .dataFlat(dataFlat)
  );

  always_comb begin
    busRdData = '0;
    if (busAddr == OFS_CTRL)  busRdData = {{(32-REQ_N){1'b0}}, ctrlReg};
    if (busAddr == OFS_STATE) busRdData = {{(32-REQ_N){1'b0}}, ackReg};
    for (int k = 0; k < DATA_WORDS; k++) begin
      if (busAddr == OFS_DATA_BASE + 8'(4 * k)) busRdData = dataFlat[k*WORD_W +: WORD_W];
    end
  end

  AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFS_CTRL) |-> (busRdData[31:REQ_N] == '0)); // R2

endmodule

// File: tb/reqack_drng_bench.sv
`timescale 1ns/1ps
module reqack_drng_bench;

  localparam logic [31:0] TAPS = 32'h80200003;
  localparam logic [31:0] SEED = 32'h6D2B79F5;
  localparam logic [31:0] MIX  = 32'hC3A50F1E;
  localparam int VEC_N = 6;

  // Table: write address, write data, read address, expected read
  localparam logic [7:0]  V_WADDR [VEC_N] = '{8'h10, 8'h44, 8'h70, 8'h14, 8'h8C, 8'h12};
  localparam logic [31:0] V_WDATA [VEC_N] = '{32'hFFFF_FFE0, 32'hDEAD_BEEF, 32'h1234_5678,
                                              32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_001F};
  localparam logic [7:0]  V_RADDR [VEC_N] = '{8'h10, 8'h44, 8'h70, 8'h14, 8'h8C, 8'h10};
  localparam logic [31:0] V_EXP   [VEC_N] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] modelState;
  logic [31:0] expWords [8];

  always #2.5 clk = ~clk;

  reqack_drng u_reqack_drng (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  function automatic logic [31:0] stepModel(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic waitAck(input string tag, input logic [31:0] mask);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 400; i++) begin
      busRead(8'h14, v);
      if ((v & mask) == mask) break;
    end
    check(tag, v & mask, mask);
  endtask

  task automatic runModelDrng(input logic [31:0] start);
    logic [31:0] s;
    s = start;
    for (int k = 0; k < 8; k++) begin
      s = stepModel(s);
      expWords[k] = s;
    end
    modelState = s;
  endtask

  task automatic checkWords(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 8; k++) begin
      busRead(8'h70 + 8'(4 * k), v);
      check(tag, v, expWords[k]);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held0;
    logic [31:0] held7;
    int firstSeen [5];

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    busRead(8'h10, v); check("R1 ctrl", v, 32'h0);
    busRead(8'h14, v); check("R1 state", v, 32'h0);
    busRead(8'h70, v); check("R1 word0", v, 32'h0);
    busRead(8'h8C, v); check("R1 word7", v, 32'h0);

    // R2 / R3 / R10: vector table of register accesses
    for (int i = 0; i < VEC_N; i++) begin
      busWrite(V_WADDR[i], V_WDATA[i]);
      busRead(V_RADDR[i], v);
      check($sformatf("R2/R3/R10 vector %0d", i), v, V_EXP[i]);
    end

    // R8: DRNG before any instantiate seeds implicitly
    busWrite(8'h10, 32'h08);
    busRead(8'h10, v); check("R2 ctrl readback", v, 32'h08);
    waitAck("R8 drng ack", 32'h08);
    repeat (20) @(negedge clk);
    busRead(8'h14, v); check("R8 only drng ack", v, 32'h08);
    busWrite(8'h14, v);
    busRead(8'h14, v); check("R3 writeback clears", v, 32'h0);
    runModelDrng(SEED);
    checkWords("R8 R5 implicit seed words");
    busWrite(8'h10, 32'h0);
    busRead(8'h10, v); check("R2 clear requests", v, 32'h0);

    // R4 / R5: second DRNG continues from state; held request does not repeat
    busWrite(8'h10, 32'h08);
    waitAck("R5 drng ack", 32'h08);
    busWrite(8'h14, 32'h08);
    runModelDrng(modelState);
    checkWords("R5 continued words");
    repeat (40) @(negedge clk);
    busRead(8'h14, v); check("R4 no repeat ack", v, 32'h0);
    busRead(8'h70, v); check("R4 words unchanged", v, expWords[0]);
    busWrite(8'h10, 32'h0);

    // R6: instantiate then DRNG
    busWrite(8'h10, 32'h01);
    waitAck("R6 inst ack", 32'h01);
    busWrite(8'h14, 32'h01);
    busWrite(8'h10, 32'h0);
    busWrite(8'h10, 32'h08);
    waitAck("R6 drng ack", 32'h08);
    busWrite(8'h14, 32'h08);
    busWrite(8'h10, 32'h0);
    runModelDrng(SEED);
    checkWords("R6 words after instantiate");

    // R6: reseed mixes constant
    busWrite(8'h10, 32'h02);
    waitAck("R6 reseed ack", 32'h02);
    busWrite(8'h14, 32'h02);
    busWrite(8'h10, 32'h0);
    busWrite(8'h10, 32'h08);
    waitAck("R6 drng after reseed ack", 32'h08);
    busWrite(8'h14, 32'h08);
    busWrite(8'h10, 32'h0);
    runModelDrng(modelState ^ MIX);
    checkWords("R6 words after reseed");

    // R9: test and TRNG leave data; R3 partial clear
    busRead(8'h70, held0);
    busRead(8'h8C, held7);
    busWrite(8'h10, 32'h14);
    waitAck("R9 test+trng acks", 32'h14);
    busRead(8'h70, v); check("R9 word0 unchanged", v, held0);
    busRead(8'h8C, v); check("R9 word7 unchanged", v, held7);
    busWrite(8'h14, 32'h04);
    busRead(8'h14, v); check("R3 partial clear", v, 32'h10);
    busWrite(8'h14, 32'h10);
    busRead(8'h14, v); check("R3 second clear", v, 32'h0);
    busWrite(8'h10, 32'h0);

    // R7: all requests together, fixed order
    for (int b = 0; b < 5; b++) firstSeen[b] = -1;
    busWrite(8'h10, 32'h1F);
    for (int c = 0; c < 200; c++) begin
      busRead(8'h14, v);
      for (int b = 0; b < 5; b++) begin
        if (v[b] && firstSeen[b] < 0) firstSeen[b] = c;
      end
    end
    check("R7 all acks", v, 32'h1F);
    for (int b = 1; b < 5; b++) begin
      check($sformatf("R7 order bit %0d after bit %0d", b, b - 1),
            32'(firstSeen[b] > firstSeen[b-1]), 32'h1);
    end
    runModelDrng(SEED ^ MIX);
    checkWords("R7 words after inst+reseed");
    busWrite(8'h14, v);
    busRead(8'h14, v); check("R3 clear all", v, 32'h0);
    busWrite(8'h10, 32'h0);

    // R10: unmapped write then read
    busWrite(8'h48, 32'hFFFF_FFFF);
    busRead(8'h48, v); check("R10 unmapped", v, 32'h0);
    busRead(8'h70, v); check("R10 words kept", v, expWords[0]);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule